// File: doc/BRIEF.md
# Low-Bit Scrambler with Overrange Tagging

This block sits on a sample output path, ahead of a serializer. It takes one data word per valid strobe and rewrites it according to a 3-bit transform selector. Some transforms flip the whole word with one pseudo-random bit per sample and carry that bit inside the word, so a receiver can undo the flip. Other transforms put the sample's overrange flag into one of the low bits. Two transforms do both.

The pseudo-random bit comes from an internal 31-stage shift register. The register steps once for every accepted sample, whatever the selector is. The result is registered, so the output appears one clock after the input. The output valid strobe follows the input strobe with the same delay. Between valid samples the output word holds its last value.

Top module: `lsb_scrambler`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, out_valid is 0 and out_data is all zeros.
- R2: Selector 3'b000 and selector 3'b111 both pass the input word to the output unchanged.
- R3: Selector 3'b001 XORs every bit of the word with the random bit p, then puts p itself into bit 0.
- R4: Selector 3'b010 replaces bit 0 with the overrange flag. Selector 3'b011 replaces bit 1 with the overrange flag. The other bits pass unchanged.
- R5: Selector 3'b100 XORs every bit of the word with p, then puts p into bit 1.
- R6: Selector 3'b101 XORs every bit of the word with p, then puts p into bit 0 and the overrange flag into bit 1.
- R7: Selector 3'b110 XORs every bit of the word with p, then puts p into bit 1 and the overrange flag into bit 2.
- R8: p is bit 30 of a 31-bit shift register seeded to 31'h4B3C2D1E. On each valid sample, whatever the selector, the register shifts left by one, and its new bit 0 is old bit 30 XOR old bit 27. Without a valid sample the register does not move.
- R9: When in_valid is presented, out_valid and the transformed word appear on the next clock edge. When in_valid is low, out_valid is low one edge later.
- R10: A cycle with in_valid low leaves out_data unchanged.
- R11: In every scrambling selector, XORing the output word with the bit found at the p position recovers every input bit that was not overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample word |
| in_ovr | input | 1 | Overrange flag of the input sample |
| mode | input | 3 | Transform selector |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Transformed word |

## Verification
The hardest case to reach is a scrambling selector in a cycle where p is 1, with the selector changing between samples. If the stimulus does not reach it, an inverted word or a misplaced tag bit looks like correct pass-through. The shift register is seeded so that p is high on the very first samples. Random stimulus then changes the selector, the data and the overrange flag on every sample and drops valid about a quarter of the time. Dropping valid checks that the shift register holds still and that the output word is held.

// File: rtl/lsb_scr_pkg.sv
package lsb_scr_pkg;

    typedef enum logic [2:0] {
        XF_PASS      = 3'b000,
        XF_SCR_B0    = 3'b001,
        XF_OVR_B0    = 3'b010,
        XF_OVR_B1    = 3'b011,
        XF_SCR_B1    = 3'b100,
        XF_SCR_OVR1  = 3'b101,
        XF_SCR_OVR2  = 3'b110,
        XF_SPARE     = 3'b111
    } xform_e;

    localparam int unsigned PRBS_LEN  = 31;
    localparam int unsigned PRBS_TAP  = 28;
    localparam logic [PRBS_LEN-1:0] PRBS_SEED = 31'h4B3C2D1E;

endpackage

// File: rtl/lsb_scr_lfsr.sv
module lsb_scr_lfsr #(
    parameter int unsigned LEN  = lsb_scr_pkg::PRBS_LEN,
    parameter int unsigned TAP  = lsb_scr_pkg::PRBS_TAP,
    parameter logic [LEN-1:0] SEED = lsb_scr_pkg::PRBS_SEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic prbs
);
    logic [LEN-1:0] shreg_d, shreg_q;
    logic           fb;

    always_comb begin
        fb      = shreg_q[LEN-1] ^ shreg_q[TAP-1];
        shreg_d = shreg_q;
        if (step) begin
            shreg_d = {shreg_q[LEN-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= SEED;
        end else begin
            shreg_q <= shreg_d;
        end
    end

    assign prbs = shreg_q[LEN-1];
endmodule

// File: rtl/lsb_scr_xform.sv
module lsb_scr_xform
    import lsb_scr_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] din,
    input  logic              ovr,
    input  logic              prbs,
    input  logic [2:0]        sel,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] flipped;

    always_comb begin
        flipped = din ^ {DATA_W{prbs}};
        dout    = din;
        unique case (xform_e'(sel))
            XF_SCR_B0: begin
                dout    = flipped;
                dout[0] = prbs;
            end
            XF_OVR_B0: dout[0] = ovr;
            XF_OVR_B1: dout[1] = ovr;
            XF_SCR_B1: begin
                dout    = flipped;
                dout[1] = prbs;
            end
            XF_SCR_OVR1: begin
                dout    = flipped;
                dout[0] = prbs;
                dout[1] = ovr;
            end
            XF_SCR_OVR2: begin
                dout    = flipped;
                dout[1] = prbs;
                dout[2] = ovr;
            end
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/lsb_scrambler.sv
module lsb_scrambler #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_ovr,
    input  logic [2:0]        mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_reg_t;

    out_reg_t          st_d, st_q;
    logic              prbs_bit;
    logic [DATA_W-1:0] xf_word;

    lsb_scr_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (in_valid),
        .prbs  (prbs_bit)
    );

    lsb_scr_xform #(.DATA_W(DATA_W)) u_xform (
        .din  (in_data),
        .ovr  (in_ovr),
        .prbs (prbs_bit),
        .sel  (mode),
        .dout (xf_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.data = xf_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
endmodule

// File: rtl/lsb_scrambler_chk.sv
module lsb_scrambler_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_ovr,
    input logic [2:0]        mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 3'b000 || mode == 3'b111)) |=> out_data == $past(in_data));

    p_ovr_b0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'b010) |=>
            (out_data[0] == $past(in_ovr)) && (out_data[DATA_W-1:1] == $past(in_data[DATA_W-1:1])));

    p_scr_b0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'b001) |=>
            (out_data[DATA_W-1:1] ^ {(DATA_W-1){out_data[0]}}) == $past(in_data[DATA_W-1:1]));

    p_scr_ovr1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'b101) |=> out_data[1] == $past(in_ovr));

    p_scr_ovr2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'b110) |=>
            (out_data[2] == $past(in_ovr)) &&
            ((out_data[DATA_W-1:3] ^ {(DATA_W-3){out_data[1]}}) == $past(in_data[DATA_W-1:3])));
endmodule

bind lsb_scrambler lsb_scrambler_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ovr    (in_ovr),
    .mode      (mode),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/lsb_scrambler_bench.sv
`timescale 1ns/1ps
module lsb_scrambler_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [W-1:0] in_data;
    logic         in_ovr;
    logic [2:0]   mode;
    logic         out_valid;
    logic [W-1:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [30:0]  mdl_sr;
    logic [W-1:0] mdl_out;

    always #10 clk = ~clk;

    lsb_scrambler #(.DATA_W(W)) u_lsb_scrambler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ovr(in_ovr), .mode(mode), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [W-1:0] xf(input logic [W-1:0] d, input logic o,
                                        input logic p, input logic [2:0] m);
        logic [W-1:0] r;
        r = d;
        case (m)
            3'b001: begin r = d ^ {W{p}}; r[0] = p; end
            3'b010: r[0] = o;
            3'b011: r[1] = o;
            3'b100: begin r = d ^ {W{p}}; r[1] = p; end
            3'b101: begin r = d ^ {W{p}}; r[0] = p; r[1] = o; end
            3'b110: begin r = d ^ {W{p}}; r[1] = p; r[2] = o; end
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'b001: return "R3";
            3'b010, 3'b011: return "R4";
            3'b100: return "R5";
            3'b101: return "R6";
            3'b110: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then check at the next falling edge.
    task automatic step(input logic v, input logic [W-1:0] d, input logic o, input logic [2:0] m);
        logic         p;
        logic [W-1:0] prev;
        logic [W-1:0] rec;
        logic [W-1:0] msk;
        int           ppos;
        in_valid = v; in_data = d; in_ovr = o; mode = m;
        p    = mdl_sr[30];
        prev = mdl_out;
        if (v) begin
            mdl_out = xf(d, o, p, m);
            mdl_sr  = {mdl_sr[29:0], mdl_sr[30] ^ mdl_sr[27]};   // R8 model
        end
        @(negedge clk);
        check("R9", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, v});
        if (v) begin
            check({req_of(m), "/R8"}, out_data, mdl_out);
            if (m == 3'b001 || m == 3'b100 || m == 3'b101 || m == 3'b110) begin
                ppos = (m == 3'b001 || m == 3'b101) ? 0 : 1;
                msk  = '1;
                msk[ppos] = 1'b0;
                if (m == 3'b101) msk[1] = 1'b0;
                if (m == 3'b110) msk[2] = 1'b0;
                rec = out_data ^ {W{out_data[ppos]}};
                check("R11", rec & msk, d & msk);
            end
        end else begin
            check("R10", out_data, prev);
        end
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240917);
        mdl_sr  = 31'h4B3C2D1E;
        mdl_out = '0;
        rst_n = 1'b0; in_valid = 1'b1; in_data = 16'hFFFF; in_ovr = 1'b1; mode = 3'b001;
        repeat (3) @(negedge clk);
        check("R1", out_data, '0);
        check("R1", {{(W-1){1'b0}}, out_valid}, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", out_data, '0);
        check("R1", {{(W-1){1'b0}}, out_valid}, '0);

        // directed: each selector with a distinctive word, p starts high
        step(1, 16'h1234, 1, 3'b000);   // R2
        step(1, 16'hA5A5, 0, 3'b001);   // R3
        step(1, 16'h00FF, 1, 3'b010);   // R4
        step(1, 16'hFF00, 1, 3'b011);   // R4
        step(1, 16'h0F0F, 0, 3'b100);   // R5
        step(0, 16'hDEAD, 1, 3'b101);   // R10, R8 hold
        step(1, 16'h8001, 1, 3'b101);   // R6
        step(1, 16'h7FFE, 1, 3'b110);   // R7
        step(1, 16'hBEEF, 0, 3'b111);   // R2
        step(1, 16'hFFFF, 1, 3'b110);   // R7 all ones
        step(1, 16'h0000, 1, 3'b001);   // R3 all zeros

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, W'($urandom), 1'($urandom), 3'($urandom));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule